// File: doc/BRIEF.md
# Modulo Timer Counter with Selectable Overflow Flag Timing

This block is a timer counter whose width is a parameter and defaults to 16 bits. It moves one step on each cycle where the tick enable is high. The counter runs upward and returns to zero after the programmed modulo value. A modulo of zero makes it free-run across the full range. A center-aligned mode is also available: the counter climbs to the modulo value, descends back to zero, and repeats.

The block keeps a sticky overflow flag and issues a one-cycle overflow event. In up-counting mode, a select input chooses when the flag is set. The late choice sets it on the rollover to zero, so software that reacts to the flag reads a count of zero. The early choice sets it when the count arrives at the modulo value, one tick before the rollover. In center-aligned mode the flag is set at the turnaround, when the count leaves the modulo value and drops to the next lower value.

The modulo input is sampled into an internal limit register only while the count is zero. A new modulo value therefore starts to apply at the next wrap. Software clears the flag with a strobe.

Top module: `wrapTimer`

## Requirements
- R1: After reset the count is 0, the flag and the event are low, and the count direction is upward. The first center-mode tick therefore moves the count to 1.
- R2: The count changes only on clock edges where `tickEn` is high. With `tickEn` low the count holds.
- R3: With an effective modulo of 0, up-counting runs 0, 1, …, 0xFFFF and then wraps to 0.
- R4: With a nonzero modulo M in up-counting mode, the count runs 0 to M. The tick after reaching M returns it to 0, giving a period of M+1 ticks.
- R5: In up-counting mode with `earlyMode` = 0, the flag is set by the tick that moves the count from the limit to 0. The first cycle with the flag high shows a count of 0.
- R6: In up-counting mode with `earlyMode` = 1, the flag is set by the tick that moves the count onto the limit. No flag is set at the rollover that follows.
- R7: In center mode (`centerMode` = 1) the count climbs to the limit and then descends. On reaching 0 it climbs again. With M = 0 the limit is 0xFFFF.
- R8: In center mode the flag is set by the tick that moves the count from the limit to the limit minus 1, whatever the value of `earlyMode`.
- R9: `ovfEvent` is high for exactly the one cycle that follows each edge at which a flag-set condition occurs. This holds even if the flag was already set.
- R10: The flag stays set until a cycle with `flagClr` high. When a set and a clear occur in the same cycle, the flag ends up set.
- R11: `modValue` is captured on every edge at which the count is 0. A change made while the count is nonzero does not alter the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Count-enable tick |
| modValue | input | CNT_W | Modulo value; 0 selects the full range |
| centerMode | input | 1 | 1 selects up/down center-aligned counting |
| earlyMode | input | 1 | 1 sets the flag when the count reaches the limit (up mode only) |
| flagClr | input | 1 | Clears the overflow flag |
| count | output | CNT_W | Current count |
| ovfFlag | output | 1 | Sticky overflow flag |
| ovfEvent | output | 1 | One-cycle pulse on each overflow condition |

## Verification
The hardest situation to reach is a full-range free-run wrap at the default 16-bit width. The stimulus ticks through all 65536 states, and during that run it changes the modulo so that the new value has to wait for the wrap. It is also difficult to make a flag set and a software clear land on the same edge. The bench produces that case by holding the clear strobe high through whole periods. A sweep then covers every small modulo value in late, early and center modes, with gaps in the ticks and scattered clears. A bench-side arithmetic model predicts the count, flag and event for each edge.

// File: rtl/wrapTimerPkg.sv
package wrapTimerPkg;

  // Strobes issued by the control to the datapath for one clock edge.
  typedef struct packed {
    logic incr;       // count + 1
    logic decr;       // count - 1
    logic clearCnt;   // count to zero
    logic goDown;     // direction becomes downward
    logic goUp;       // direction becomes upward
    logic loadLimit;  // capture modulo input into limit register
    logic setFlag;    // overflow condition on this edge
    logic clrFlag;    // software clear request
  } strobeT;

endpackage

// File: rtl/wrapTimerCtrl.sv
module wrapTimerCtrl
  import wrapTimerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             tickEn,
  input  logic             centerMode,
  input  logic             earlyMode,
  input  logic             flagClr,
  input  logic [CNT_W-1:0] count,
  input  logic             dirDown,
  input  logic [CNT_W-1:0] limitReg,
  output strobeT           strobes
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] effLimit;
  logic [CNT_W-1:0] countPlus;
  logic             atLimit;
  logic             atZero;
  logic             nextIsLimit;

  always_comb begin
    effLimit    = (limitReg == '0) ? ALL_ONES : limitReg;
    countPlus   = count + ONE;
    atLimit     = (count == effLimit);
    atZero      = (count == '0);
    nextIsLimit = (countPlus == effLimit);
  end

  always_comb begin
    strobes           = '0;
    strobes.loadLimit = atZero;
    strobes.clrFlag   = flagClr;
    strobes.goUp      = !centerMode;
    if (tickEn) begin
      if (!centerMode) begin
        if (atLimit) begin
          strobes.clearCnt = 1'b1;
          strobes.setFlag  = !earlyMode;
        end else begin
          strobes.incr     = 1'b1;
          strobes.setFlag  = earlyMode && nextIsLimit;
        end
      end else if (dirDown) begin
        if (atZero) begin
          strobes.incr = 1'b1;
          strobes.goUp = 1'b1;
        end else begin
          strobes.decr = 1'b1;
        end
      end else if (atLimit) begin
        strobes.decr    = 1'b1;
        strobes.goDown  = 1'b1;
        strobes.setFlag = 1'b1;
      end else begin
        strobes.incr = 1'b1;
      end
    end
  end

endmodule

// File: rtl/wrapTimerPath.sv
module wrapTimerPath
  import wrapTimerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobes,
  input  logic [CNT_W-1:0] modValue,
  output logic [CNT_W-1:0] count,
  output logic             dirDown,
  output logic [CNT_W-1:0] limitReg,
  output logic             ovfFlag,
  output logic             ovfEvent
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      dirDown  <= 1'b0;
      limitReg <= '0;
      ovfFlag  <= 1'b0;
      ovfEvent <= 1'b0;
    end else begin
      if (strobes.clearCnt)  count <= '0;
      else if (strobes.incr) count <= count + ONE;
      else if (strobes.decr) count <= count - ONE;

      if (strobes.goDown)    dirDown <= 1'b1;
      else if (strobes.goUp) dirDown <= 1'b0;

      if (strobes.loadLimit) limitReg <= modValue;

      if (strobes.setFlag)      ovfFlag <= 1'b1;
      else if (strobes.clrFlag) ovfFlag <= 1'b0;

      ovfEvent <= strobes.setFlag;
    end
  end

endmodule

// File: rtl/wrapTimer.sv
module wrapTimer
  import wrapTimerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic [CNT_W-1:0] modValue,
  input  logic             centerMode,
  input  logic             earlyMode,
  input  logic             flagClr,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag,
  output logic             ovfEvent
);

  strobeT           strobes;
  logic             dirDown;
  logic [CNT_W-1:0] limitReg;

  wrapTimerCtrl #(.CNT_W(CNT_W)) ctrl (
    .tickEn    (tickEn),
    .centerMode(centerMode),
    .earlyMode (earlyMode),
    .flagClr   (flagClr),
    .count     (count),
    .dirDown   (dirDown),
    .limitReg  (limitReg),
    .strobes   (strobes)
  );

  wrapTimerPath #(.CNT_W(CNT_W)) path (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .modValue(modValue),
    .count   (count),
    .dirDown (dirDown),
    .limitReg(limitReg),
    .ovfFlag (ovfFlag),
    .ovfEvent(ovfEvent)
  );

endmodule

// File: rtl/wrapTimerChecker.sv
module wrapTimerChecker
  import wrapTimerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             centerMode,
  input logic             earlyMode,
  input logic             flagClr,
  input logic [CNT_W-1:0] count,
  input logic             ovfFlag,
  input logic             ovfEvent,
  input strobeT           strobes
);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(count));

  assert_full_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !centerMode && count == {CNT_W{1'b1}}) |=> (count == '0));

  assert_late_sees_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ovfEvent && !$past(centerMode) && !$past(earlyMode)) |-> (count == '0));

  assert_center_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && centerMode) |=>
      ((count == CNT_W'($past(count) + 1'b1)) || (count == CNT_W'($past(count) - 1'b1))));

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfEvent && $past(centerMode)) |-> (count == CNT_W'($past(count) - 1'b1)));

  assert_event_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvent |-> ovfFlag);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setFlag |=> (ovfFlag && ovfEvent));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !flagClr) |=> ovfFlag);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !strobes.setFlag) |=> !ovfFlag);

endmodule

bind wrapTimer wrapTimerChecker #(.CNT_W(CNT_W)) checkerInst (
  .clk       (clk),
  .rstN      (rstN),
  .tickEn    (tickEn),
  .centerMode(centerMode),
  .earlyMode (earlyMode),
  .flagClr   (flagClr),
  .count     (count),
  .ovfFlag   (ovfFlag),
  .ovfEvent  (ovfEvent),
  .strobes   (strobes)
);

// File: tb/wrapTimer_test.sv
`timescale 1ns/1ps
module wrapTimer_test;

  localparam int          CNT_W = 16;
  localparam logic [15:0] MAXV  = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        centerMode = 1'b0;
  logic        earlyMode = 1'b0;
  logic        flagClr = 1'b0;
  logic [15:0] modValue = '0;
  logic [15:0] count;
  logic        ovfFlag;
  logic        ovfEvent;

  wrapTimer #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .modValue(modValue),
    .centerMode(centerMode), .earlyMode(earlyMode), .flagClr(flagClr),
    .count(count), .ovfFlag(ovfFlag), .ovfEvent(ovfEvent)
  );

  always #2 clk = ~clk;  // 250 MHz

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string phase  = "R1";

  // Bench-side expectation state
  logic [15:0] mCount  = '0;
  logic [15:0] mShadow = '0;
  bit          mDown   = 1'b0;
  bit          mFlag   = 1'b0;
  bit          mEvent  = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic advanceModel(input bit tk, input bit clr);
    logic [15:0] lim;
    logic [15:0] nc;
    bit          set;
    lim = (mShadow == 16'd0) ? MAXV : mShadow;
    nc  = mCount;
    set = 1'b0;
    if (tk) begin
      if (!centerMode) begin
        if (mCount == lim) begin
          nc = 16'd0; set = !earlyMode;
        end else begin
          nc = mCount + 16'd1; set = earlyMode && (nc == lim);
        end
      end else if (mDown) begin
        if (mCount == 16'd0) begin nc = 16'd1; mDown = 1'b0; end
        else nc = mCount - 16'd1;
      end else if (mCount == lim) begin
        nc = mCount - 16'd1; mDown = 1'b1; set = 1'b1;
      end else begin
        nc = mCount + 16'd1;
      end
    end
    if (!centerMode) mDown = 1'b0;
    if (mCount == 16'd0) mShadow = modValue;
    mCount = nc;
    if (set) mFlag = 1'b1;
    else if (clr) mFlag = 1'b0;
    mEvent = set;
  endtask

  task automatic step(input bit tk, input bit clr);
    tickEn  = tk;
    flagClr = clr;
    @(posedge clk);
    advanceModel(tk, clr);
    #1;
    check(count == mCount, phase, "count", count, mCount);
    check(ovfFlag == mFlag, {phase, " R10"}, "flag", ovfFlag, mFlag);
    check(ovfEvent == mEvent, {phase, " R9"}, "event", ovfEvent, mEvent);
    @(negedge clk);
  endtask

  task automatic runToZero();
    while (count != 16'd0) step(1'b1, 1'b0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2: actual %0d expected %0d (run did not complete)", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(count == 16'd0, "R1", "count at reset", count, 0);
    check(ovfFlag == 1'b0, "R1", "flag at reset", ovfFlag, 0);
    check(ovfEvent == 1'b0, "R1", "event at reset", ovfEvent, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: direction starts upward
    phase = "R1 R7";
    centerMode = 1'b1;
    step(1'b1, 1'b0);
    check(count == 16'd1, "R1", "first center tick", count, 1);
    step(1'b1, 1'b0);
    centerMode = 1'b0;
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);

    // R2: no ticks, count holds
    phase = "R2";
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
    check(count == 16'd4, "R2", "held count", count, 4);

    // R3 / R5 / R11: full-range run; a modulo change waits for the wrap
    phase = "R3 R5";
    runToZero();
    for (int i = 0; i < 65536; i++) begin
      if (i == 40000) modValue = 16'd6;
      step(1'b1, i == 100);
      if (i == 65534) check(count == MAXV, "R3", "top of range", count, MAXV);
    end
    check(count == 16'd0, "R3", "wrap to zero", count, 0);
    check(ovfFlag == 1'b1, "R5", "late flag sees zero", ovfFlag, 1);

    // R4 / R5 with gaps in the ticks and scattered clears
    phase = "R4 R5";
    for (int i = 0; i < 40; i++) step((i % 3) != 2, (i % 9) == 4);
    runToZero();
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    check(count == 16'd6, "R4", "reaches modulo", count, 6);
    step(1'b1, 1'b1);
    check(count == 16'd0, "R4", "wrap after modulo", count, 0);
    check(ovfFlag == 1'b1, "R10", "set beats clear", ovfFlag, 1);

    // R10: clear held high through periods
    phase = "R10";
    modValue = 16'd3;
    for (int i = 0; i < 16; i++) step(1'b1, 1'b1);

    // R6: early flag
    phase = "R6";
    modValue = 16'd4;
    earlyMode = 1'b1;
    runToZero();
    step(1'b1, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    check(count == 16'd4 && ovfEvent, "R6", "early flag at modulo", ovfEvent, 1);
    step(1'b1, 1'b1);
    check(count == 16'd0 && !ovfFlag, "R6", "no flag at rollover", ovfFlag, 0);
    for (int i = 0; i < 20; i++) step(1'b1, (i % 6) == 0);
    earlyMode = 1'b0;

    // R11: modulo change mid-period
    phase = "R11";
    modValue = 16'd5;
    runToZero();
    step(1'b1, 1'b0);
    runToZero();
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    modValue = 16'd3;
    step(1'b1, 1'b0);
    check(count == 16'd5, "R11", "old limit still in force", count, 5);
    step(1'b1, 1'b0);
    check(count == 16'd0, "R11", "wrap at old limit", count, 0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    check(count == 16'd0, "R11", "new limit after wrap", count, 0);

    // R7 / R8: center mode, both flag selections
    phase = "R7 R8";
    modValue = 16'd5;
    centerMode = 1'b1;
    earlyMode = 1'b1;
    runToZero();
    step(1'b1, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    check(count == 16'd5 && !ovfFlag, "R8", "no flag on reaching limit", ovfFlag, 0);
    step(1'b1, 1'b0);
    check(count == 16'd4 && ovfEvent, "R8", "flag at turnaround", ovfEvent, 1);
    for (int i = 0; i < 30; i++) step((i % 5) != 4, (i % 8) == 1);
    earlyMode = 1'b0;
    for (int i = 0; i < 30; i++) step(1'b1, (i % 7) == 3);

    // Sweep of small modulo values over all three flag behaviours
    for (int m = 1; m <= 20; m++) begin
      for (int mode = 0; mode < 3; mode++) begin
        modValue   = 16'(m);
        centerMode = (mode == 2);
        earlyMode  = (mode == 1);
        phase = (mode == 0) ? "R4 R5" : (mode == 1) ? "R6" : "R7 R8";
        runToZero();
        for (int k = 0; k < 2 * m + 6; k++) step((k % 7) != 6, (k % 5) == 3);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule